// File: doc/BRIEF.md
# Sized Little-Endian Memory Access Port

This block carries out one load or store at a time on behalf of a requester. Each access moves one, two or four bytes of a byte-addressed memory that the block contains. The requester presents a virtual address, a size in bytes, a write flag and write data. The block first checks that the size is legal. It then hands the virtual address, the size and the write flag to an external translation unit and waits for that unit's answer. The translation unit can enforce write protection, alignment and page validity.

If the translator answers with a nonzero exception code, the block ends the access without reading or writing memory. It reports the code, raises a failure status and keeps the faulting virtual address in a register. That register is updated by faults only. If the translator answers cleanly, the block uses the returned physical address for the access. The memory is organised as four byte-wide banks, and the byte enables come from the size and the two low physical address bits. Stores write only the low bytes of the data, and loads return the value zero-extended to 32 bits. Multi-byte values are little-endian: the lowest address holds the least significant byte.

Top module: `mem_access_port`

## Requirements
- R1: After synchronous active-low reset, `done`, `busy`, `xlat_req` and `ok` are 0, and `bad_vaddr` and `exc_code` are 0.
- R2: A request with a legal size (`req_size` of 1, 2 or 4), accepted while `busy` is 0, raises `xlat_req` in the next cycle. `xlat_vaddr`, `xlat_size` and `xlat_write` carry the request's values. `xlat_req` stays high with stable values until the cycle in which `xlat_done` is sampled high.
- R3: A request whose `req_size` is not 1, 2 or 4 is never sent to the translator. In the cycle after acceptance, `done`=1, `ok`=0 and `exc_code`=7, and `bad_vaddr` takes the request's virtual address.
- R4: If `xlat_exc` is nonzero when `xlat_done` is sampled, memory is not touched. In the next cycle, `done`=1, `ok`=0, `exc_code` equals `xlat_exc`, `rdata`=0 and `bad_vaddr` equals the request's virtual address.
- R5: Memory is little-endian. Byte k of a stored word (bits 8k+7:8k) lands at physical address base+k, and loads assemble bytes in the same order.
- R6: A 1-byte store writes only data bits 7:0, and a 2-byte store writes only bits 15:0. All other bytes of the addressed word keep their contents.
- R7: A successful load returns the byte or halfword at the physical address zero-extended to 32 bits. A successful store returns `rdata`=0.
- R8: `bad_vaddr` changes only on a failed access (R3 or R4). Successful accesses leave it unchanged.
- R9: After a clean translation (`xlat_done` sampled with `xlat_exc`=0), `done` and `ok` are 1 exactly two cycles later, with `exc_code`=0. `done` is a single-cycle pulse per request.
- R10: While `busy` is 1, `req_valid` is ignored: the translator inputs do not change and no extra completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is 0 |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_vaddr | input | VA_W | Virtual address |
| req_wdata | input | 32 | Store data (low bytes used for sub-word sizes) |
| busy | output | 1 | An access is in progress |
| xlat_req | output | 1 | Translation request, held until answered |
| xlat_write | output | 1 | Write flag passed to the translator |
| xlat_size | output | 3 | Access size passed to the translator |
| xlat_vaddr | output | VA_W | Virtual address passed to the translator |
| xlat_done | input | 1 | Translator answer strobe |
| xlat_exc | input | EXC_W | Translator exception code, 0 = none |
| xlat_paddr | input | PA_W | Translated physical byte address |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Completion status, 1 = success |
| rdata | output | 32 | Zero-extended load result |
| exc_code | output | EXC_W | Exception code of the completed access |
| bad_vaddr | output | VA_W | Virtual address of the most recent failed access |

## Verification
A wrong byte-enable pattern or lane shift does not show at the ports when the store happens. It shows at the first later load that covers the damaged neighbour byte, so the bench reads back whole words after each sub-word store. A sequencer that slips a state shows up at once as `done` one cycle early or late, or as `xlat_req` dropping before the answer. The faulting-address register or the fault suppression can be wrong without any sign until the next completion, where `bad_vaddr` or the untouched memory contents are compared.

// File: rtl/mapt_pkg.sv
// Shared constants and types for the memory access port.
// Assumes a 32-bit data path split into four byte lanes.
package mapt_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int OFS_W  = $clog2(LANES);

    typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_BAD} size_e;
    typedef enum logic [1:0] {ST_IDLE, ST_XLAT, ST_ACCESS} state_e;

    // Map a byte count onto the internal size code.
    function automatic size_e decode_size(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return SZ_BYTE;
            3'd2:    return SZ_HALF;
            3'd4:    return SZ_WORD;
            default: return SZ_BAD;
        endcase
    endfunction

    // Number of bytes touched by a size code.
    function automatic int size_bytes(input size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/mapt_lanes.sv
// Byte-lane steering between a 32-bit value and a memory row.
// Produces byte enables from the size and the row offset, moves store
// data into its lanes, and extracts and zero-extends load data.
// Assumes an aligned access: offset + size never exceeds the row.
module mapt_lanes
    import mapt_pkg::*;
(
    input  size_e                 size,
    input  logic [OFS_W-1:0]      offset,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W-1:0]     row_rdata,
    output logic [LANES-1:0]      be,
    output logic [DATA_W-1:0]     lane_wdata,
    output logic [DATA_W-1:0]     load_data
);
    logic [LANES-1:0]  size_mask;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] keep;

    // Lanes used by the access before moving them to the row offset.
    always_comb begin
        case (size)
            SZ_BYTE: size_mask = 4'b0001;
            SZ_HALF: size_mask = 4'b0011;
            SZ_WORD: size_mask = 4'b1111;
            default: size_mask = 4'b0000;
        endcase
    end

    // Enables and store data move up by the offset, load data moves down.
    always_comb begin
        be         = size_mask << offset;
        lane_wdata = wdata << (BYTE_W * offset);
        shifted    = row_rdata >> (BYTE_W * offset);
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_keep
            assign keep[g*BYTE_W +: BYTE_W] = {BYTE_W{size_mask[g]}};
        end
    endgenerate

    assign load_data = shifted & keep;
endmodule

// File: rtl/mapt_banks.sv
// Byte-addressed storage built as one byte-wide bank per lane.
// Writes are per-lane under byte enables. Reads are asynchronous,
// one full row at a time. There is no reset: contents start undefined.
module mapt_banks
    import mapt_pkg::*;
#(
    parameter int ROW_W = 6
) (
    input  logic                clk,
    input  logic                we,
    input  logic [LANES-1:0]    be,
    input  logic [ROW_W-1:0]    row,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    localparam int ROWS = 1 << ROW_W;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_bank
            logic [BYTE_W-1:0] bank [ROWS];

            // Store this lane's byte when its enable is set.
            always_ff @(posedge clk) begin
                if (we && be[g])
                    bank[row] <= wdata[g*BYTE_W +: BYTE_W];
            end

            assign rdata[g*BYTE_W +: BYTE_W] = bank[row];
        end
    endgenerate
endmodule

// File: rtl/mem_access_port.sv
// Sized little-endian load/store port with an external translation step.
// Takes one request at a time. Illegal sizes fail at once. Legal requests
// are translated first, and a translator exception ends the access
// without touching memory. Otherwise one access cycle reads or writes
// the banks. Assumes the translator rejects misaligned accesses.
module mem_access_port
    import mapt_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 8,
    parameter int EXC_W   = 3,
    parameter int EXC_BAD_SIZE = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [2:0]         req_size,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               xlat_req,
    output logic               xlat_write,
    output logic [2:0]         xlat_size,
    output logic [VA_W-1:0]    xlat_vaddr,
    input  logic               xlat_done,
    input  logic [EXC_W-1:0]   xlat_exc,
    input  logic [PA_W-1:0]    xlat_paddr,
    output logic               done,
    output logic               ok,
    output logic [DATA_W-1:0]  rdata,
    output logic [EXC_W-1:0]   exc_code,
    output logic [VA_W-1:0]    bad_vaddr
);
    localparam int ROW_W = PA_W - OFS_W;

    state_e             state;
    logic               write_q;
    logic [2:0]         nbytes_q;
    size_e              size_q;
    logic [VA_W-1:0]    vaddr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [PA_W-1:0]    paddr_q;

    logic [LANES-1:0]   be;
    logic [DATA_W-1:0]  lane_wdata;
    logic [DATA_W-1:0]  row_rdata;
    logic [DATA_W-1:0]  load_data;
    logic               mem_we;

    assign mem_we = (state == ST_ACCESS) && write_q;

    // Sequencer: accept, translate, access, and report the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            write_q   <= 1'b0;
            nbytes_q  <= '0;
            size_q    <= SZ_BAD;
            vaddr_q   <= '0;
            wdata_q   <= '0;
            paddr_q   <= '0;
            done      <= 1'b0;
            ok        <= 1'b0;
            rdata     <= '0;
            exc_code  <= '0;
            bad_vaddr <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        write_q  <= req_write;
                        nbytes_q <= req_size;
                        size_q   <= decode_size(req_size);
                        vaddr_q  <= req_vaddr;
                        wdata_q  <= req_wdata;
                        if (decode_size(req_size) == SZ_BAD) begin
                            done      <= 1'b1;
                            ok        <= 1'b0;
                            rdata     <= '0;
                            exc_code  <= EXC_W'(EXC_BAD_SIZE);
                            bad_vaddr <= req_vaddr;
                        end else begin
                            state <= ST_XLAT;
                        end
                    end
                end
                ST_XLAT: begin
                    if (xlat_done) begin
                        if (xlat_exc != '0) begin
                            done      <= 1'b1;
                            ok        <= 1'b0;
                            rdata     <= '0;
                            exc_code  <= xlat_exc;
                            bad_vaddr <= vaddr_q;
                            state     <= ST_IDLE;
                        end else begin
                            paddr_q <= xlat_paddr;
                            state   <= ST_ACCESS;
                        end
                    end
                end
                ST_ACCESS: begin
                    done     <= 1'b1;
                    ok       <= 1'b1;
                    exc_code <= '0;
                    rdata    <= write_q ? '0 : load_data;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign xlat_req   = (state == ST_XLAT);
    assign xlat_write = write_q;
    assign xlat_size  = nbytes_q;
    assign xlat_vaddr = vaddr_q;

    mapt_lanes u_lanes (
        .size       (size_q),
        .offset     (paddr_q[OFS_W-1:0]),
        .wdata      (wdata_q),
        .row_rdata  (row_rdata),
        .be         (be),
        .lane_wdata (lane_wdata),
        .load_data  (load_data)
    );

    mapt_banks #(.ROW_W(ROW_W)) u_banks (
        .clk   (clk),
        .we    (mem_we),
        .be    (be),
        .row   (paddr_q[PA_W-1:OFS_W]),
        .wdata (lane_wdata),
        .rdata (row_rdata)
    );

    // R2: the translation request holds steady until it is answered.
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req && !xlat_done) |=> (xlat_req && $stable(xlat_vaddr)));

    // R4: a memory write only follows a clean translator answer.
    a_r4_write_after_clean: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(xlat_done && xlat_exc == '0));

    // R6: the number of enabled lanes matches the access size.
    a_r6_be_count: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(be) == size_bytes(size_q)));

    // R3: a failed completion always carries a nonzero code.
    a_r3_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> (exc_code != '0));

    // R8: the faulting address changes only with a failed completion.
    a_r8_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && !ok) |-> $stable(bad_vaddr));
endmodule

// File: tb/mem_access_port_tb.sv
`timescale 1ns/1ps
module mem_access_port_tb;
    localparam int VA_W = 32;
    localparam int PA_W = 8;
    localparam int EXC_W = 3;
    localparam int MEM_BYTES = 1 << PA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [2:0]        req_size = '0;
    logic [VA_W-1:0]   req_vaddr = '0;
    logic [31:0]       req_wdata = '0;
    logic              busy, xlat_req, xlat_write;
    logic [2:0]        xlat_size;
    logic [VA_W-1:0]   xlat_vaddr;
    logic              xlat_done = 1'b0;
    logic [EXC_W-1:0]  xlat_exc = '0;
    logic [PA_W-1:0]   xlat_paddr = '0;
    logic              done, ok;
    logic [31:0]       rdata;
    logic [EXC_W-1:0]  exc_code;
    logic [VA_W-1:0]   bad_vaddr;

    int checks = 0;
    int errors = 0;
    logic [7:0]        ref_mem [MEM_BYTES];
    logic [VA_W-1:0]   exp_bad = '0;

    always #4 clk = ~clk;

    mem_access_port u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
        .busy(busy), .xlat_req(xlat_req), .xlat_write(xlat_write),
        .xlat_size(xlat_size), .xlat_vaddr(xlat_vaddr), .xlat_done(xlat_done),
        .xlat_exc(xlat_exc), .xlat_paddr(xlat_paddr), .done(done), .ok(ok),
        .rdata(rdata), .exc_code(exc_code), .bad_vaddr(bad_vaddr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request end to end, compared cycle by cycle with the model.
    task automatic access(input logic wr, input int sz, input logic [31:0] va,
                          input logic [31:0] wd, input logic [7:0] pa,
                          input logic [2:0] ex, input int lat, input bit poke);
        logic [31:0] exp_r;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = 3'(sz);
        req_vaddr = va;   req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (!(sz == 1 || sz == 2 || sz == 4)) begin
            exp_bad = va;
            chk("R3 done", 32'(done), 1);
            chk("R3 ok", 32'(ok), 0);
            chk("R3 exc_code", 32'(exc_code), 7);
            chk("R3 no xlat_req", 32'(xlat_req), 0);
            chk("R3 bad_vaddr", bad_vaddr, exp_bad);
            return;
        end
        for (int k = 0; k < lat; k++) begin
            chk("R2 xlat_req", 32'(xlat_req), 1);
            chk("R2 xlat_vaddr", xlat_vaddr, va);
            chk("R2 xlat_size", 32'(xlat_size), 32'(sz));
            chk("R2 xlat_write", 32'(xlat_write), 32'(wr));
            chk("R10 busy", 32'(busy), 1);
            chk("R9 no early done", 32'(done), 0);
            req_valid = poke && (k == 0);
            req_vaddr = ~va;
            if (k == lat - 1) begin
                xlat_done = 1'b1; xlat_exc = ex; xlat_paddr = pa;
            end
            @(negedge clk);
        end
        xlat_done = 1'b0; xlat_exc = '0; req_valid = 1'b0;
        if (ex != 0) begin
            exp_bad = va;
            chk("R4 done", 32'(done), 1);
            chk("R4 ok", 32'(ok), 0);
            chk("R4 exc_code", 32'(exc_code), 32'(ex));
            chk("R4 rdata", rdata, 0);
            chk("R4 bad_vaddr", bad_vaddr, exp_bad);
            return;
        end
        chk("R9 access cycle", 32'(done), 0);
        @(negedge clk);
        exp_r = 0;
        for (int b = 0; b < sz; b++) begin
            if (wr) ref_mem[8'(pa + b)] = wd[8*b +: 8];
            else    exp_r[8*b +: 8] = ref_mem[8'(pa + b)];
        end
        chk("R9 done", 32'(done), 1);
        chk("R9 ok", 32'(ok), 1);
        chk("R9 exc_code", 32'(exc_code), 0);
        chk("R5/R7 rdata", rdata, exp_r);
        chk("R8 bad_vaddr held", bad_vaddr, exp_bad);
        @(negedge clk);
        chk("R9 single pulse", 32'(done), 0);
        if (poke) chk("R10 ignored request", 32'(busy), 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done", 32'(done), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 xlat_req", 32'(xlat_req), 0);
        chk("R1 ok", 32'(ok), 0);
        chk("R1 bad_vaddr", bad_vaddr, 0);
        chk("R1 exc_code", 32'(exc_code), 0);
        rst_n = 1'b1;

        // R5: a word store, then byte and halfword loads.
        access(1, 4, 32'h1000, 32'h4433_2211, 8'h20, 0, 1, 0);
        for (int b = 0; b < 4; b++)
            access(0, 1, 32'h1000 + b, 0, 8'(8'h20 + b), 0, 1, 0);
        access(0, 2, 32'h1002, 0, 8'h22, 0, 2, 0);
        // R6: sub-word stores keep neighbour bytes intact.
        access(1, 1, 32'h1001, 32'hAABB_CCDD, 8'h21, 0, 1, 0);
        access(0, 4, 32'h1000, 0, 8'h20, 0, 1, 0);
        access(1, 2, 32'h1002, 32'h1234_5678, 8'h22, 0, 1, 0);
        access(0, 4, 32'h1000, 0, 8'h20, 0, 1, 0);
        // R7: zero extension of all-ones data.
        access(1, 4, 32'h2040, 32'hFFFF_FFFF, 8'h40, 0, 1, 0);
        access(0, 1, 32'h2043, 0, 8'h43, 0, 1, 0);
        access(0, 2, 32'h2042, 0, 8'h42, 0, 1, 0);
        // R4: a faulting store leaves memory unchanged.
        access(1, 4, 32'h000D_EAD0, 32'h0, 8'h20, 3'd3, 2, 0);
        access(0, 4, 32'h1000, 0, 8'h20, 0, 1, 0);
        // R3: illegal sizes.
        access(0, 3, 32'h0000_BEEF, 0, 8'h00, 0, 1, 0);
        access(1, 0, 32'h0000_CAFE, 0, 8'h00, 0, 1, 0);
        // R8: successful accesses after faults keep bad_vaddr.
        access(0, 4, 32'h2040, 0, 8'h40, 0, 3, 0);
        // R10: a request during translation is ignored; long latency.
        access(0, 2, 32'h1000, 0, 8'h20, 0, 4, 1);
        // R4: a read-side fault with another code; row at the top of memory.
        access(0, 1, 32'h0000_0777, 0, 8'h00, 3'd5, 1, 0);
        access(1, 4, 32'h3FFC, 32'hCAFE_F00D, 8'hFC, 0, 1, 0);
        access(0, 2, 32'h3FFE, 0, 8'hFE, 0, 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule